// File: doc/BRIEF.md
# DDR3 command timing gate

This block sits between a memory command scheduler and the DDR3 command bus and decides, for every rank, whether an activate, read, write, precharge or clock-enable toggle may go out in the current DCLK. Configuration software supplies the timing fields already converted to DCLK units. The block adds the fixed offsets to those fields and raises any field that is too small to its hard clock floor. It then runs one saturating down-counter per spacing rule and per rank. Each counter is loaded when the command that starts its rule is issued.

The scheduler offers one command per cycle with a valid/ready handshake. The command is issued on the clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is the legal-to-issue flag for the offered kind and rank. The same flags are also exported per rank so that the scheduler can choose among candidates. When a rank-multiplying buffered module is fitted, all physical ranks count as one logical rank for write-to-read spacing.

Top module: `ddr3_cmd_gate`

## Requirements
- R1: After reset, every legal-to-issue flag of every rank is high and every rank's clock-enable level is low.
- R2: A write to a rank blocks reads to that same rank for cfg_cwl + 4 + cfg_twtr DCLKs. With a write issued on edge e, the read may issue at edge e + that spacing and not before.
- R3: A write to one rank blocks reads to every other rank for the 5-bit spacing {cfg_twrdr_hi, cfg_twrdr_lo}, where the high field supplies bits 4:3. A spacing of 0 or 1 places no restriction.
- R4: Any read or write to a rank blocks both reads and writes to that rank for cfg_tccd + 4 DCLKs.
- R5: A read to a rank blocks precharge to that rank for max(cfg_trtp, 4) DCLKs. A smaller programmed value is clamped up to 4 and is not rejected.
- R6: An activate to a rank blocks the next activate to that rank for max(cfg_trrd, 4) DCLKs.
- R7: A clock-enable toggle flips that rank's level output on the issuing edge. The next toggle on that rank is blocked for max(cfg_tcke, 3) DCLKs.
- R8: With cfg_rank_mult high, a write to any rank blocks reads to all ranks by the same-rank spacing of R2. The different-rank spacing of R3 is not applied.
- R9: Command kinds are encoded 0 activate, 1 read, 2 write, 3 precharge, 4 clock-enable toggle. `cmd_ready` equals the flag of the offered kind and rank. Codes 5 to 7 are never ready and have no effect.
- R10: A command is issued only on an edge where valid and ready are both high, so at most one command issues per DCLK. An offered command that is not ready, or an idle cycle, leaves all timing state and levels unchanged.
- R11: Counters saturate at zero. When a load arrives while a counter is still running, the counter keeps the longer of the two remaining spans. Apart from R3 and R8, a command on one rank does not affect the flags of another rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DCLK |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_kind | input | 3 | Command kind code (R9) |
| cmd_rank | input | RANK_W | Target rank of the offered command |
| cfg_cwl | input | 5 | CAS write latency in DCLKs |
| cfg_twtr | input | 4 | Same-rank write-to-read field |
| cfg_twrdr_lo | input | 3 | Different-rank write-to-read, bits 2:0 |
| cfg_twrdr_hi | input | 2 | Different-rank write-to-read, bits 4:3 |
| cfg_tccd | input | 3 | CAS-to-CAS field (4 is added) |
| cfg_trtp | input | 4 | Read-to-precharge spacing |
| cfg_trrd | input | 4 | Activate-to-activate spacing |
| cfg_tcke | input | 4 | Minimum clock-enable pulse width |
| cfg_rank_mult | input | 1 | Treat all ranks as one logical rank for write-to-read |
| cmd_ready | output | 1 | Offered command may issue this cycle |
| allow_act | output | NUM_RANKS | Per-rank activate flag |
| allow_rd | output | NUM_RANKS | Per-rank read flag |
| allow_wr | output | NUM_RANKS | Per-rank write flag |
| allow_pre | output | NUM_RANKS | Per-rank precharge flag |
| allow_cke | output | NUM_RANKS | Per-rank clock-enable toggle flag |
| cke_level | output | NUM_RANKS | Current clock-enable level per rank |

## Verification
A read flag can be held low by three rules at once: the same-rank write-to-read spacing, the cross-rank spacing, and the CAS-to-CAS spacing. A second write can also reload a counter that is still running. The bench provokes these overlaps with long random streams of mixed reads and writes on both ranks under several timing sets, including settings where the cross-rank span exceeds the CAS span and the reverse. Every cycle, each flag is compared against a reference model that tracks, for each rank and command, the earliest cycle at which it becomes legal. The reference takes the maximum over all pending rules.

// File: rtl/ddr3_gate_pkg.sv
package ddr3_gate_pkg;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_CKE = 3'd4
    } gate_cmd_e;

    // Counter width: holds cwl(31) + 4 + twtr(15) = 50
    localparam int SPAN_W = 6;

    // Fixed offsets and clock floors
    localparam int WTR_OFFSET = 4;
    localparam int CAS_OFFSET = 4;
    localparam int RTP_FLOOR  = 4;
    localparam int RRD_FLOOR  = 4;
    localparam int CKE_FLOOR  = 3;

    // Rule slots inside a rank
    localparam int RULE_WTR  = 0;
    localparam int RULE_WRDR = 1;
    localparam int RULE_CCD  = 2;
    localparam int RULE_RTP  = 3;
    localparam int RULE_RRD  = 4;
    localparam int RULE_CKE  = 5;
    localparam int RULE_CNT  = 6;

    typedef logic [SPAN_W-1:0] span_t;
    typedef span_t [RULE_CNT-1:0] span_set_t;

    function automatic int floor_clamp(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

    // A spacing of N clocks is held by loading N-1 at issue
    function automatic span_t gap_load(input int gap);
        return (gap <= 1) ? span_t'(0) : span_t'(gap - 1);
    endfunction

endpackage

// File: rtl/gate_down_counter.sv
module gate_down_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);
    logic [W-1:0] cnt;
    logic [W-1:0] dec;

    always_comb begin
        dec = (cnt == '0) ? '0 : cnt - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load && (load_val > dec))
            cnt <= load_val;
        else
            cnt <= dec;
    end

    assign idle = (cnt == '0);

    // R11: zero is a resting state without a load
    a_r11_saturates_at_zero: assert property (@(posedge clk) disable iff (rst)
        (idle && !load) |=> idle);

    // R11: a nonzero load always leaves the counter running
    a_r11_load_holds_off: assert property (@(posedge clk) disable iff (rst)
        (load && (load_val != '0)) |=> !idle);

endmodule

// File: rtl/gate_rank_slot.sv
module gate_rank_slot
    import ddr3_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  span_set_t spans,
    input  logic      hit_act,
    input  logic      hit_rd,
    input  logic      hit_wr,
    input  logic      hit_cke,
    input  logic      wr_same,
    input  logic      wr_other,
    output logic      ok_act,
    output logic      ok_rd,
    output logic      ok_wr,
    output logic      ok_pre,
    output logic      ok_cke,
    output logic      cke_lvl
);
    logic [RULE_CNT-1:0] trig;
    logic [RULE_CNT-1:0] idle;

    always_comb begin
        trig            = '0;
        trig[RULE_WTR]  = wr_same;
        trig[RULE_WRDR] = wr_other;
        trig[RULE_CCD]  = hit_rd | hit_wr;
        trig[RULE_RTP]  = hit_rd;
        trig[RULE_RRD]  = hit_act;
        trig[RULE_CKE]  = hit_cke;
    end

    for (genvar i = 0; i < RULE_CNT; i++) begin : g_rule
        gate_down_counter #(.W(SPAN_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (trig[i]),
            .load_val (spans[i]),
            .idle     (idle[i])
        );
    end

    assign ok_rd  = idle[RULE_WTR] & idle[RULE_WRDR] & idle[RULE_CCD];
    assign ok_wr  = idle[RULE_CCD];
    assign ok_pre = idle[RULE_RTP];
    assign ok_act = idle[RULE_RRD];
    assign ok_cke = idle[RULE_CKE];

    always_ff @(posedge clk) begin
        if (rst)
            cke_lvl <= 1'b0;
        else if (hit_cke)
            cke_lvl <= ~cke_lvl;
    end

    // R4: every CAS blocks the next CAS on this rank for at least 4 clocks
    a_r4_cas_blocks_cas: assert property (@(posedge clk) disable iff (rst)
        (hit_rd || hit_wr) |=> (!ok_rd && !ok_wr));

    // R5: floor of 4 keeps precharge blocked right after a read
    a_r5_read_blocks_pre: assert property (@(posedge clk) disable iff (rst)
        hit_rd |=> !ok_pre);

    // R6: floor of 4 keeps activate blocked right after an activate
    a_r6_act_blocks_act: assert property (@(posedge clk) disable iff (rst)
        hit_act |=> !ok_act);

    // R7: toggle flips the level and starts the pulse-width lockout
    a_r7_level_flips: assert property (@(posedge clk) disable iff (rst)
        hit_cke |=> (cke_lvl != $past(cke_lvl)) && !ok_cke);

    // R10: no toggle, no level change
    a_r10_level_stable: assert property (@(posedge clk) disable iff (rst)
        !hit_cke |=> $stable(cke_lvl));

endmodule

// File: rtl/ddr3_cmd_gate.sv
module ddr3_cmd_gate
    import ddr3_gate_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_kind,
    input  logic [RANK_W-1:0]    cmd_rank,
    input  logic [4:0]           cfg_cwl,
    input  logic [3:0]           cfg_twtr,
    input  logic [2:0]           cfg_twrdr_lo,
    input  logic [1:0]           cfg_twrdr_hi,
    input  logic [2:0]           cfg_tccd,
    input  logic [3:0]           cfg_trtp,
    input  logic [3:0]           cfg_trrd,
    input  logic [3:0]           cfg_tcke,
    input  logic                 cfg_rank_mult,
    output logic                 cmd_ready,
    output logic [NUM_RANKS-1:0] allow_act,
    output logic [NUM_RANKS-1:0] allow_rd,
    output logic [NUM_RANKS-1:0] allow_wr,
    output logic [NUM_RANKS-1:0] allow_pre,
    output logic [NUM_RANKS-1:0] allow_cke,
    output logic [NUM_RANKS-1:0] cke_level
);
    span_set_t spans;
    logic      rank_in_range;
    logic      fire;

    always_comb begin
        spans            = '0;
        spans[RULE_WTR]  = gap_load(int'(cfg_cwl) + WTR_OFFSET + int'(cfg_twtr));
        spans[RULE_WRDR] = gap_load(int'({cfg_twrdr_hi, cfg_twrdr_lo}));
        spans[RULE_CCD]  = gap_load(int'(cfg_tccd) + CAS_OFFSET);
        spans[RULE_RTP]  = gap_load(floor_clamp(int'(cfg_trtp), RTP_FLOOR));
        spans[RULE_RRD]  = gap_load(floor_clamp(int'(cfg_trrd), RRD_FLOOR));
        spans[RULE_CKE]  = gap_load(floor_clamp(int'(cfg_tcke), CKE_FLOOR));
    end

    assign rank_in_range = (int'(cmd_rank) < NUM_RANKS);

    always_comb begin
        cmd_ready = 1'b0;
        if (rank_in_range) begin
            case (cmd_kind)
                CMD_ACT: cmd_ready = allow_act[cmd_rank];
                CMD_RD:  cmd_ready = allow_rd[cmd_rank];
                CMD_WR:  cmd_ready = allow_wr[cmd_rank];
                CMD_PRE: cmd_ready = allow_pre[cmd_rank];
                CMD_CKE: cmd_ready = allow_cke[cmd_rank];
                default: cmd_ready = 1'b0;
            endcase
        end
    end

    assign fire = cmd_valid & cmd_ready;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic here;
        logic fire_wr;
        assign here    = (int'(cmd_rank) == r);
        assign fire_wr = fire && (cmd_kind == CMD_WR);

        gate_rank_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .spans    (spans),
            .hit_act  (fire && (cmd_kind == CMD_ACT) && here),
            .hit_rd   (fire && (cmd_kind == CMD_RD)  && here),
            .hit_wr   (fire_wr && here),
            .hit_cke  (fire && (cmd_kind == CMD_CKE) && here),
            .wr_same  (fire_wr && (here || cfg_rank_mult)),
            .wr_other (fire_wr && !here && !cfg_rank_mult),
            .ok_act   (allow_act[r]),
            .ok_rd    (allow_rd[r]),
            .ok_wr    (allow_wr[r]),
            .ok_pre   (allow_pre[r]),
            .ok_cke   (allow_cke[r]),
            .cke_lvl  (cke_level[r])
        );
    end

    // R9: undefined kind codes are never accepted
    a_r9_undefined_kind_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_kind > 3'd4) |-> !cmd_ready);

    // R8: in rank multiplication a write blocks reads on every rank
    a_r8_mult_blocks_all_reads: assert property (@(posedge clk) disable iff (rst)
        (fire && (cmd_kind == CMD_WR) && cfg_rank_mult) |=> (allow_rd == '0));

    // R2: a write blocks reads on its own rank on the next cycle
    a_r2_write_blocks_own_read: assert property (@(posedge clk) disable iff (rst)
        (fire && (cmd_kind == CMD_WR)) |=> !allow_rd[$past(cmd_rank)]);

    // R1: flags and levels come out of reset in their idle state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (allow_act == '1 && allow_rd == '1 && allow_wr == '1 &&
                        allow_pre == '1 && allow_cke == '1 && cke_level == '0));

endmodule

// File: tb/ddr3_cmd_gate_test.sv
module ddr3_cmd_gate_test;
    localparam int NR = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_kind = 3'd0;
    logic [0:0]    cmd_rank = 1'b0;
    logic [4:0]    cfg_cwl = 5'd5;
    logic [3:0]    cfg_twtr = 4'd2;
    logic [2:0]    cfg_twrdr_lo = 3'd3;
    logic [1:0]    cfg_twrdr_hi = 2'd2;
    logic [2:0]    cfg_tccd = 3'd0;
    logic [3:0]    cfg_trtp = 4'd1;
    logic [3:0]    cfg_trrd = 4'd2;
    logic [3:0]    cfg_tcke = 4'd0;
    logic          cfg_rank_mult = 1'b0;
    logic          cmd_ready;
    logic [NR-1:0] allow_act, allow_rd, allow_wr, allow_pre, allow_cke, cke_level;

    ddr3_cmd_gate #(.NUM_RANKS(NR)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_rank(cmd_rank), .cfg_cwl(cfg_cwl), .cfg_twtr(cfg_twtr),
        .cfg_twrdr_lo(cfg_twrdr_lo), .cfg_twrdr_hi(cfg_twrdr_hi),
        .cfg_tccd(cfg_tccd), .cfg_trtp(cfg_trtp), .cfg_trrd(cfg_trrd),
        .cfg_tcke(cfg_tcke), .cfg_rank_mult(cfg_rank_mult),
        .cmd_ready(cmd_ready), .allow_act(allow_act), .allow_rd(allow_rd),
        .allow_wr(allow_wr), .allow_pre(allow_pre), .allow_cke(allow_cke),
        .cke_level(cke_level)
    );

    int checks = 0;
    int fails = 0;
    int edge_n = 0;
    bit done = 1'b0;
    int lfsr = 16'hACE1;

    // Reference model: earliest edge count at which each command is legal
    int ok_act[NR], ok_rd[NR], ok_wr[NR], ok_pre[NR], ok_cke[NR];
    bit lvl[NR];

    always @(posedge clk) edge_n++;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rnd();
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
        return lfsr;
    endfunction

    function automatic bit model_ready(input int k, input int r);
        case (k)
            0: return edge_n >= ok_act[r];
            1: return edge_n >= ok_rd[r];
            2: return edge_n >= ok_wr[r];
            3: return edge_n >= ok_pre[r];
            4: return edge_n >= ok_cke[r];
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit dut_flag(input int sel, input int r);
        case (sel)
            0: return allow_act[r];
            1: return allow_rd[r];
            2: return allow_wr[r];
            3: return allow_pre[r];
            default: return allow_cke[r];
        endcase
    endfunction

    task automatic check(input bit got, input bit exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: got %0b expected %0b", req, what, edge_n, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string req, input string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model_issue(input int k, input int r, input int e);
        int wtr, ccd;
        wtr = int'(cfg_cwl) + 4 + int'(cfg_twtr) - 1;
        ccd = int'(cfg_tccd) + 4 - 1;
        case (k)
            0: ok_act[r] = mx(ok_act[r], e + mx(int'(cfg_trrd), 4) - 1);
            1: begin
                ok_rd[r]  = mx(ok_rd[r], e + ccd);
                ok_wr[r]  = mx(ok_wr[r], e + ccd);
                ok_pre[r] = mx(ok_pre[r], e + mx(int'(cfg_trtp), 4) - 1);
            end
            2: begin
                ok_rd[r] = mx(ok_rd[r], e + ccd);
                ok_wr[r] = mx(ok_wr[r], e + ccd);
                for (int q = 0; q < NR; q++) begin
                    if (q == r || cfg_rank_mult)
                        ok_rd[q] = mx(ok_rd[q], e + wtr);
                    else
                        ok_rd[q] = mx(ok_rd[q], e + int'({cfg_twrdr_hi, cfg_twrdr_lo}) - 1);
                end
            end
            4: begin
                ok_cke[r] = mx(ok_cke[r], e + mx(int'(cfg_tcke), 3) - 1);
                lvl[r] = ~lvl[r];
            end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        for (int r = 0; r < NR; r++) begin
            check(allow_act[r], model_ready(0, r), "R6 R11", $sformatf("allow_act[%0d]", r));
            check(allow_rd[r],  model_ready(1, r), "R2 R3 R4 R8", $sformatf("allow_rd[%0d]", r));
            check(allow_wr[r],  model_ready(2, r), "R4", $sformatf("allow_wr[%0d]", r));
            check(allow_pre[r], model_ready(3, r), "R5", $sformatf("allow_pre[%0d]", r));
            check(allow_cke[r], model_ready(4, r), "R7", $sformatf("allow_cke[%0d]", r));
            check(cke_level[r], lvl[r], "R7 R10", $sformatf("cke_level[%0d]", r));
        end
    endtask

    // One DCLK: compare state, offer a command, update the model, move on
    task automatic cycle(input bit v, input int k, input int r);
        bit exp_rdy;
        compare_all();
        cmd_valid = v;
        cmd_kind  = 3'(k);
        cmd_rank  = 1'(r);
        #1;
        exp_rdy = model_ready(k, r);
        check(cmd_ready, exp_rdy, "R9 R10", $sformatf("cmd_ready kind %0d rank %0d", k, r));
        if (v && exp_rdy) model_issue(k, r, edge_n + 1);
        @(negedge clk);
    endtask

    task automatic do_reset();
        cmd_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) begin
            ok_act[r] = edge_n; ok_rd[r] = edge_n; ok_wr[r] = edge_n;
            ok_pre[r] = edge_n; ok_cke[r] = edge_n; lvl[r] = 1'b0;
        end
        check(allow_act == '1 && allow_rd == '1 && allow_wr == '1 &&
              allow_pre == '1 && allow_cke == '1, 1'b1, "R1", "all flags high after reset");
        check(cke_level == '0, 1'b1, "R1", "cke levels low after reset");
    endtask

    // Issue kind k on rank r, then count edges until flag sel of rank w rises
    task automatic measure(input int k, input int r, input int sel, input int w,
                           input int exp, input string req);
        int start, guard;
        guard = 0;
        while (!model_ready(k, r) && guard < 100) begin cycle(1'b0, 0, 0); guard++; end
        start = edge_n + 1;
        cycle(1'b1, k, r);
        guard = 0;
        while (!dut_flag(sel, w) && guard < 100) begin cycle(1'b0, 0, 0); guard++; end
        check_int(edge_n - start, exp, req, "spacing in edges minus one");
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int x;
            x = rnd();
            cycle(((x >> 3) & 3) != 0, (x >> 5) % 6, (x >> 9) & 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();                                   // R1
        measure(2, 0, 1, 1, 18, "R3");                // twrdr {2,3} = 19
        measure(1, 0, 3, 0, 3, "R5");                 // trtp 1 clamped to 4
        measure(4, 1, 4, 1, 2, "R7");                 // tcke 0 clamped to 3
        measure(0, 0, 0, 0, 3, "R6");                 // trrd 2 clamped to 4
        measure(2, 1, 1, 1, 10, "R2");                // 5 + 4 + 2
        measure(1, 1, 2, 1, 3, "R4");                 // tccd 0 + 4
        cycle(1'b1, 5, 0);                            // R9: undefined code ignored
        cycle(1'b1, 7, 1);
        random_run(400);

        cfg_cwl = 5'd9; cfg_twtr = 4'd7; cfg_tccd = 3'd3; cfg_trtp = 4'd9;
        cfg_trrd = 4'd6; cfg_tcke = 4'd5; cfg_twrdr_lo = 3'd1; cfg_twrdr_hi = 2'd0;
        random_run(400);

        cfg_rank_mult = 1'b1; cfg_cwl = 5'd5; cfg_twtr = 4'd2;
        cfg_twrdr_lo = 3'd7; cfg_twrdr_hi = 2'd3;
        repeat (60) cycle(1'b0, 0, 0);
        measure(2, 1, 1, 0, 10, "R8");                // other rank uses same-rank formula
        random_run(400);

        cfg_rank_mult = 1'b0; cfg_twrdr_lo = 3'd0; cfg_twrdr_hi = 2'd0;
        cfg_tccd = 3'd7; cfg_cwl = 5'd31; cfg_twtr = 4'd15;
        random_run(300);

        do_reset();                                   // R1 again with state pending
        compare_all();
        finish_run();
    end
endmodule